// File: doc/BRIEF.md
# Odd-Ratio Symmetric Clock Divider

This block divides an input clock by three or by five and drives a true and a complement output whose high and low phases are equal in length. An odd ratio cannot be split evenly on rising edges alone. The block therefore starts each output high phase on an input rising edge and ends it on an input falling edge. This gives 1.5 input periods high and 1.5 low at the smaller ratio, and 2.5 and 2.5 at the larger one.

A synchronous enable starts and stops the output train. Starting waits one full input cycle after the enable is seen, and stopping waits for the current output period to finish, so the output never shows a shortened pulse. An active-low master reset forces the outputs to their idle levels at once, without any clock. After reset is released, counting restarts at the top of a period. A change of the ratio select applies from the next output period onward.

Top module: `oddclk_div`

## Requirements
- R1: With `sel_five` = 0, each output period is 3 input periods long. `q` is high for 3 input half-periods and low for 3.
- R2: With `sel_five` = 1, each output period is 5 input periods long. `q` is high for 5 input half-periods and low for 5.
- R3: Every rising transition of `q` happens on a rising edge of `clk_in`.
- R4: `qn` is always the logical inverse of `q`.
- R5: While `rst_n` is 0, `q` is 0 and `qn` is 1. This takes effect immediately when `rst_n` falls, with no clock edge needed.
- R6: Once the output has stopped, `q` stays at 0 and `qn` at 1 for as long as `en` is sampled 0.
- R7: When the output is stopped and `en` is first sampled 1 on a rising edge E, `q` rises on the next rising edge after E. It stays 0 at E and through the falling edge that follows E.
- R8: When `en` is sampled 0 during a running period, the current high pulse still lasts its full width and the period completes. After that, `q` does not rise again.
- R9: After `rst_n` is released with `en` held at 1, the first high pulse has full width.
- R10: A change of `sel_five` during an output period leaves that period unchanged. The next period uses the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock. Both edges are used. |
| rst_n | input | 1 | Asynchronous master reset, active low |
| sel_five | input | 1 | Ratio select: 0 divides by 3, 1 divides by 5 |
| en | input | 1 | Synchronous output enable, sampled on rising edges |
| q | output | 1 | Divided clock, true polarity |
| qn | output | 1 | Divided clock, complement polarity |

## Verification
The hardest cases to reach are those that need precise edge timing: a ratio change, a disable or a reset that lands in the middle of an output high phase. The stimulus walks the bench in single half-period steps, and each sample is taken one nanosecond after an edge. The bench finds the rising transition of `q` and then changes the input right after it, so the change is known to fall inside the first high phase. Pulse widths are then counted in half-periods across the disturbed period and the next one. This shows whether the pulse already in flight kept its width.

// File: rtl/divr_pkg.sv
`timescale 1ns/1ps
package divr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } run_e;

    // Whole input cycles in which the rising-edge lead term stays high.
    // The falling-edge copy then adds the final half cycle.
    function automatic int lead_cycles(input int ratio);
        return (ratio - 1) / 2;
    endfunction

endpackage

// File: rtl/divr_seq.sv
`timescale 1ns/1ps
module divr_seq
    import divr_pkg::*;
#(
    parameter int RATIO_LO = 3,
    parameter int RATIO_HI = 5
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en,
    input  logic sel_hi,
    output logic lead_o
);
    localparam int CW = $clog2(RATIO_HI);
    localparam logic [CW-1:0] LAST_LO = CW'(RATIO_LO - 1);
    localparam logic [CW-1:0] LAST_HI = CW'(RATIO_HI - 1);
    localparam logic [CW-1:0] KEEP_LO = CW'(lead_cycles(RATIO_LO));
    localparam logic [CW-1:0] KEEP_HI = CW'(lead_cycles(RATIO_HI));

    typedef struct packed {
        run_e          st;
        logic [CW-1:0] cnt;
        logic          hi_sel;
        logic          lead;
    } seq_t;

    seq_t          s_d, s_q;
    logic [CW-1:0] last_d;
    logic [CW-1:0] keep_d;
    logic [CW-1:0] cnt_inc_d;

    always_comb begin
        s_d       = s_q;
        last_d    = s_q.hi_sel ? LAST_HI : LAST_LO;
        keep_d    = s_q.hi_sel ? KEEP_HI : KEEP_LO;
        cnt_inc_d = CW'(s_q.cnt + 1'b1);
        unique case (s_q.st)
            ST_IDLE: begin
                s_d.lead = 1'b0;
                s_d.cnt  = '0;
                if (en) s_d.st = ST_ARM;
            end
            ST_ARM: begin
                if (en) begin
                    s_d.st     = ST_RUN;
                    s_d.cnt    = '0;
                    s_d.hi_sel = sel_hi;
                    s_d.lead   = 1'b1;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (s_q.cnt == last_d) begin
                    s_d.cnt = '0;
                    if (en) begin
                        s_d.hi_sel = sel_hi;
                        s_d.lead   = 1'b1;
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.lead = 1'b0;
                    end
                end else begin
                    s_d.cnt  = cnt_inc_d;
                    s_d.lead = (cnt_inc_d < keep_d);
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lead_o = s_q.lead;

endmodule

// File: rtl/divr_fall.sv
`timescale 1ns/1ps
module divr_fall (
    input  logic clk_in,
    input  logic rst_n,
    input  logic lead_i,
    output logic trail_o
);
    logic trail_d, trail_q;

    always_comb begin
        trail_d = lead_i;
    end

    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) trail_q <= 1'b0;
        else        trail_q <= trail_d;
    end

    assign trail_o = trail_q;

endmodule

// File: rtl/divr_out.sv
`timescale 1ns/1ps
module divr_out (
    input  logic lead_i,
    input  logic trail_i,
    output logic q_o,
    output logic qn_o
);
    logic level;

    always_comb begin
        level = lead_i | trail_i;
        q_o   = level;
        qn_o  = ~level;
    end

endmodule

// File: rtl/oddclk_div.sv
`timescale 1ns/1ps
module oddclk_div #(
    parameter int RATIO_LO = 3,
    parameter int RATIO_HI = 5
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic sel_five,
    input  logic en,
    output logic q,
    output logic qn
);
    logic lead_w;
    logic trail_w;

    divr_seq #(
        .RATIO_LO(RATIO_LO),
        .RATIO_HI(RATIO_HI)
    ) u_seq (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .en     (en),
        .sel_hi (sel_five),
        .lead_o (lead_w)
    );

    divr_fall u_fall (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .lead_i  (lead_w),
        .trail_o (trail_w)
    );

    divr_out u_out (
        .lead_i  (lead_w),
        .trail_i (trail_w),
        .q_o     (q),
        .qn_o    (qn)
    );

endmodule

// File: rtl/divr_chk.sv
`timescale 1ns/1ps
module divr_chk (
    input logic clk_in,
    input logic rst_n,
    input logic en,
    input logic q,
    input logic qn
);
    // R4: complement output mirrors the true output on both clock phases
    a_r4_comp_rise: assert property (@(posedge clk_in) disable iff (!rst_n)
        qn == !q);
    a_r4_comp_fall: assert property (@(negedge clk_in) disable iff (!rst_n)
        qn == !q);

    // R5: reset holds the idle output levels
    a_r5_reset_idle: assert property (@(posedge clk_in)
        !rst_n |-> (!q && qn));

    // R6: no new pulse can start while the enable is sampled low
    a_r6_no_start: assert property (@(posedge clk_in) disable iff (!rst_n)
        !en |=> !$rose(q));

    // R1: a high phase always outlasts the falling edge that follows its start
    a_r1_high_span: assert property (@(negedge clk_in) disable iff (!rst_n)
        $rose(q) |=> q);

endmodule

bind oddclk_div divr_chk u_divr_chk (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .en     (en),
    .q      (q),
    .qn     (qn)
);

// File: tb/oddclk_div_bench.sv
`timescale 1ns/1ps
module oddclk_div_bench;

    logic clk_in = 1'b0;
    logic rst_n;
    logic sel_five;
    logic en;
    logic q, qn;

    int checks = 0;
    int errors = 0;
    int inv_bad = 0;
    logic cur = 1'b0;
    logic ph  = 1'b0;

    always #2.5 clk_in = ~clk_in;

    oddclk_div u_oddclk_div (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .sel_five (sel_five),
        .en       (en),
        .q        (q),
        .qn       (qn)
    );

    // {sel_five, expected high half-periods, expected low half-periods}
    localparam logic [8:0] VEC [4] = '{
        {1'b0, 4'd3, 4'd3},
        {1'b1, 4'd5, 4'd5},
        {1'b1, 4'd5, 4'd5},
        {1'b0, 4'd3, 4'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one half-period step: sample 1 ns after the next clock edge
    task automatic step();
        @(posedge clk_in or negedge clk_in);
        ph = clk_in;
        #1;
        cur = q;
        if (qn !== ~q) inv_bad++;
    endtask

    task automatic wait_rise();
        logic prev;
        bit found = 0;
        for (int i = 0; i < 100; i++) begin
            prev = cur;
            step();
            if (cur && !prev) begin found = 1; break; end
        end
        if (!found) chk(0, "rise-timeout", 0, 1);
    endtask

    task automatic run_len(output int n);
        logic v0 = cur;
        n = 1;
        for (int i = 0; i < 50; i++) begin
            step();
            if (cur == v0) n++;
            else break;
        end
    endtask

    task automatic to_rise_phase();
        step();
        while (ph != 1'b1) step();
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hw, lw, h2;
        bit all_low;
        rst_n = 1'b0; en = 1'b0; sel_five = 1'b0;
        #12;
        chk(q === 1'b0 && qn === 1'b1, "R5 reset state", q, 0);
        @(posedge clk_in); #1 rst_n = 1'b1;

        // R6: stays stopped with en low
        all_low = 1;
        for (int i = 0; i < 8; i++) begin
            step();
            if (cur !== 1'b0) all_low = 0;
        end
        chk(all_low, "R6 idle after reset", cur, 0);

        // R7: start latency
        to_rise_phase();
        en = 1'b1;
        step(); step();
        chk(cur === 1'b0, "R7 low at sampling edge", cur, 0);
        step();
        chk(cur === 1'b0, "R7 low after following fall", cur, 0);
        step();
        chk(cur === 1'b1 && ph == 1'b1, "R7 rise on next rising edge", cur, 1);

        // table of ratio and width vectors (R1, R2, R3)
        foreach (VEC[k]) begin
            sel_five = VEC[k][8];
            wait_rise();
            chk(ph == 1'b1, "R3 rise on input rising edge", ph, 1);
            run_len(hw);
            run_len(lw);
            chk(hw == int'(VEC[k][7:4]), VEC[k][8] ? "R2 high width" : "R1 high width",
                hw, int'(VEC[k][7:4]));
            chk(lw == int'(VEC[k][3:0]), VEC[k][8] ? "R2 low width" : "R1 low width",
                lw, int'(VEC[k][3:0]));
        end

        // R10: ratio change inside a period, 3 -> 5
        sel_five = 1'b0;
        wait_rise(); wait_rise();
        sel_five = 1'b1;
        run_len(hw); run_len(lw); run_len(h2);
        chk(hw == 3 && lw == 3, "R10 current period kept /3", hw * 10 + lw, 33);
        chk(h2 == 5, "R10 next period /5", h2, 5);
        // R10: 5 -> 3
        wait_rise();
        sel_five = 1'b0;
        run_len(hw); run_len(lw); run_len(h2);
        chk(hw == 5 && lw == 5, "R10 current period kept /5", hw * 10 + lw, 55);
        chk(h2 == 3, "R10 next period /3", h2, 3);

        // R8 / R6: disable inside a /3 high pulse
        wait_rise();
        en = 1'b0;
        run_len(hw);
        chk(hw == 3, "R8 /3 last pulse full", hw, 3);
        all_low = 1;
        for (int i = 0; i < 20; i++) begin
            step();
            if (cur !== 1'b0 || qn !== 1'b1) all_low = 0;
        end
        chk(all_low, "R6 held low after /3 stop", cur, 0);

        // R8 / R6: disable inside a /5 high pulse
        sel_five = 1'b1;
        en = 1'b1;
        wait_rise();
        en = 1'b0;
        run_len(hw);
        chk(hw == 5, "R8 /5 last pulse full", hw, 5);
        all_low = 1;
        for (int i = 0; i < 20; i++) begin
            step();
            if (cur !== 1'b0 || qn !== 1'b1) all_low = 0;
        end
        chk(all_low, "R6 held low after /5 stop", cur, 0);

        // R5 / R9: reset in the middle of a high phase
        en = 1'b1;
        wait_rise();
        step();
        chk(cur === 1'b1, "R5 pre-reset high", cur, 1);
        rst_n = 1'b0;
        #0.5;
        chk(q === 1'b0 && qn === 1'b1, "R5 immediate reset", q, 0);
        for (int i = 0; i < 4; i++) step();
        chk(cur === 1'b0, "R5 held in reset", cur, 0);
        to_rise_phase();
        rst_n = 1'b1;
        wait_rise();
        run_len(hw);
        chk(hw == 5, "R9 first pulse full", hw, 5);

        chk(inv_bad == 0, "R4 complement mismatches", inv_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule